// File: doc/BRIEF.md
# LPC Single-Byte Memory Read Target

This block is the target side of a Low Pin Count bus. It handles one kind of transaction: a read of a single byte from memory. It samples the active-low frame strobe and the 4-bit shared data lines on every bus clock. It recognises a start nibble and checks the cycle-type nibble. It then gathers the address one nibble per clock, starting with the most significant nibble. After that it takes part in the bus turnaround, signals that data is ready, and returns the byte in two nibbles with the low half first. It ends by handing the bus back through a closing turnaround.

A backing memory sits behind the block. It sees the assembled address together with a one-clock request pulse and supplies the byte a fixed number of clocks later, set by a parameter. The byte is registered before the data clocks begin. A separate output-enable signal controls the tristate buffer outside the block. The block drives it high only during the clocks in which the target owns the lines.

Top module: `lpc_rd_target`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, `lad_oe` and `mem_req` are low.
- R2: While `frame_n` is high and no cycle is in progress, any value on `lad_in`, including 0000, causes no response: `lad_oe` and `mem_req` stay low.
- R3: While `frame_n` is held low for several clocks, only the nibble present in the last of those clocks is taken as the start field. A cycle starts only if that nibble is 0000, whatever came before it.
- R4: The cycle-type nibble is taken in the first clock with `frame_n` high. Bits 3:2 must be 01 and bit 1 must be 0. Bit 0 is ignored, so 0100 and 0101 both start a read.
- R5: The next eight clocks carry the address, most significant nibble first. In the clock after the last address nibble (first turnaround), `mem_req` is high for exactly one clock, and `mem_addr` holds the assembled address and stays stable afterwards.
- R6: In the first turnaround clock `lad_oe` is low. In the second turnaround clock `lad_oe` is high and `lad_out` is 1111.
- R7: In the clock after the second turnaround, the target drives the ready sync code 0000.
- R8: The two clocks after sync carry the byte that the memory presented `MEM_LAT` clocks after the `mem_req` clock: bits 3:0 first, then bits 7:4.
- R9: In the first closing turnaround clock the target drives 1111. In the second it releases the lines (`lad_oe` low). A new cycle may start in the very next clock. A full read spans 17 clocks.
- R10: If the cycle-type nibble is not a memory read, the target returns to idle. It raises neither `lad_oe` nor `mem_req` until a later valid start.
- R11: `frame_n` going low in any clock aborts the cycle in progress. `lad_oe` is low in the next clock, and a start nibble 0000 in that clock begins a new cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every action is on the rising edge |
| rst_n | input | 1 | Active-low reset to idle |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Nibble sampled from the shared lines |
| lad_out | output | 4 | Nibble the target drives when enabled |
| lad_oe | output | 1 | Output enable for the external tristate buffer |
| mem_addr | output | ADDR_W | Assembled address for the backing memory |
| mem_req | output | 1 | One-clock read request to the backing memory |
| mem_rdata | input | 8 | Byte returned by the memory `MEM_LAT` clocks after the request |

## Verification
The assertions assume a well-behaved host. It keeps `frame_n` high through the turnaround, sync and data clocks of a read, except when it deliberately aborts. They also assume the memory holds `mem_rdata` valid in the clock `MEM_LAT` after the request. The bench drives every nibble half a clock away from the sampling edge. It models the memory as an arithmetic function of the address that returns deliberately wrong data outside the valid clock, so a mistimed capture shows up. The bench sweeps all sixteen cycle-type codes, idle streams with every nibble, long start runs, walking-one addresses and an abort in the sync clock. Apart from that abort, `frame_n` stays high whenever the target is driving.

// File: rtl/lpc_rd_pkg.sv
package lpc_rd_pkg;

   localparam int NIB_W = 4;
   localparam int BYTE_W = 8;

   localparam logic [NIB_W-1:0] NIB_START = 4'h0;
   localparam logic [NIB_W-1:0] NIB_HIGH  = 4'hF;
   localparam logic [NIB_W-1:0] NIB_READY = 4'h0;
   // upper three bits of a memory-read cycle type; bit 0 is don't-care
   localparam logic [2:0]       CT_MEM_RD = 3'b010;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_START,
      ST_ADDR,
      ST_TAR0,
      ST_TAR1,
      ST_SYNC,
      ST_DLO,
      ST_DHI,
      ST_ETAR0,
      ST_ETAR1
   } lpc_st_e;

endpackage

// File: rtl/lpc_rd_fsm.sv
module lpc_rd_fsm
   import lpc_rd_pkg::*;
#(
   parameter int NIBBLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic [NIB_W-1:0] lad_in,
   output lpc_st_e          state,
   output logic             shift_en,
   output logic             req
);

   localparam int CNT_W = $clog2(NIBBLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NIBBLES - 1);

   lpc_st_e          nxt;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      nxt = ST_IDLE;
      if (!frame_n) begin
         nxt = (lad_in == NIB_START) ? ST_START : ST_IDLE;
      end else begin
         case (state)
            ST_IDLE:  nxt = ST_IDLE;
            ST_START: nxt = (lad_in[3:1] == CT_MEM_RD) ? ST_ADDR : ST_IDLE;
            ST_ADDR:  nxt = (cnt == CNT_LAST) ? ST_TAR0 : ST_ADDR;
            ST_TAR0:  nxt = ST_TAR1;
            ST_TAR1:  nxt = ST_SYNC;
            ST_SYNC:  nxt = ST_DLO;
            ST_DLO:   nxt = ST_DHI;
            ST_DHI:   nxt = ST_ETAR0;
            ST_ETAR0: nxt = ST_ETAR1;
            ST_ETAR1: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         state <= nxt;
         if (state == ST_ADDR && frame_n) cnt <= cnt + 1'b1;
         else                             cnt <= '0;
      end
   end

   assign shift_en = (state == ST_ADDR) && frame_n;
   assign req      = (state == ST_TAR0);

endmodule

// File: rtl/lpc_rd_addr_shift.sv
module lpc_rd_addr_shift
   import lpc_rd_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic [NIB_W-1:0]  nib_in,
   output logic [ADDR_W-1:0] addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr <= '0;
      else if (shift_en) addr <= {addr[ADDR_W-NIB_W-1:0], nib_in};
   end

endmodule

// File: rtl/lpc_rd_data_cap.sv
module lpc_rd_data_cap
   import lpc_rd_pkg::*;
#(
   parameter int MEM_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [BYTE_W-1:0] rdata,
   output logic [BYTE_W-1:0] data_q
);

   logic take;

   generate
      if (MEM_LAT == 1) begin : g_direct
         logic req_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_d <= 1'b0;
            else        req_d <= req;
         end
         assign take = req_d;
      end else begin : g_pipe
         logic [MEM_LAT-1:0] req_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_p <= '0;
            else        req_p <= {req_p[MEM_LAT-2:0], req};
         end
         assign take = req_p[MEM_LAT-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    data_q <= '0;
      else if (take) data_q <= rdata;
   end

endmodule

// File: rtl/lpc_rd_lad_mux.sv
module lpc_rd_lad_mux
   import lpc_rd_pkg::*;
(
   input  lpc_st_e           state,
   input  logic [BYTE_W-1:0] data_q,
   output logic [NIB_W-1:0]  lad_out,
   output logic              lad_oe
);

   always_comb begin
      lad_out = NIB_HIGH;
      lad_oe  = 1'b0;
      case (state)
         ST_TAR1:  begin lad_oe = 1'b1; lad_out = NIB_HIGH;    end
         ST_SYNC:  begin lad_oe = 1'b1; lad_out = NIB_READY;   end
         ST_DLO:   begin lad_oe = 1'b1; lad_out = data_q[3:0]; end
         ST_DHI:   begin lad_oe = 1'b1; lad_out = data_q[7:4]; end
         ST_ETAR0: begin lad_oe = 1'b1; lad_out = NIB_HIGH;    end
         default:  begin lad_oe = 1'b0; lad_out = NIB_HIGH;    end
      endcase
   end

endmodule

// File: rtl/lpc_rd_target.sv
module lpc_rd_target
   import lpc_rd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int MEM_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        lad_in,
   output logic [3:0]        lad_out,
   output logic              lad_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_req,
   input  logic [7:0]        mem_rdata
);

   localparam int NIBBLES = ADDR_W / NIB_W;

   generate
      if (ADDR_W % NIB_W != 0 || NIBBLES < 2 || (NIBBLES & (NIBBLES - 1)) != 0) begin : g_bad_addr
         $error("lpc_rd_target: ADDR_W must be a power-of-two count of nibbles, at least two");
      end
      if (MEM_LAT < 1 || MEM_LAT > 2) begin : g_bad_lat
         $error("lpc_rd_target: MEM_LAT must be 1 or 2 so the byte is ready before the data clocks");
      end
   endgenerate

   lpc_st_e           state;
   logic              shift_en;
   logic [BYTE_W-1:0] data_q;

   lpc_rd_fsm #(.NIBBLES(NIBBLES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_n  (frame_n),
      .lad_in   (lad_in),
      .state    (state),
      .shift_en (shift_en),
      .req      (mem_req)
   );

   lpc_rd_addr_shift #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .nib_in   (lad_in),
      .addr     (mem_addr)
   );

   lpc_rd_data_cap #(.MEM_LAT(MEM_LAT)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (mem_req),
      .rdata  (mem_rdata),
      .data_q (data_q)
   );

   lpc_rd_lad_mux u_mux (
      .state   (state),
      .data_q  (data_q),
      .lad_out (lad_out),
      .lad_oe  (lad_oe)
   );

endmodule

// File: rtl/lpc_rd_target_chk.sv
module lpc_rd_target_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n,
   input logic [3:0]        lad_out,
   input logic              lad_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_req
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!lad_oe && !mem_req));

   // R6
   tar0_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !lad_oe);

   // R6
   tar1_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && frame_n) |=> (lad_oe && lad_out == 4'hF));

   // R7
   sync_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lad_oe) && frame_n) |=> (lad_oe && lad_out == 4'h0));

   // R5
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> (!mem_req && $stable(mem_addr)));

   // R11
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |=> (!lad_oe && !mem_req));

endmodule

bind lpc_rd_target lpc_rd_target_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lpc_rd_target_tb.sv
module lpc_rd_target_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int BLAT       = 2;
   localparam int AW         = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_n = 1'b1;
   logic [3:0]    lad_in = 4'hF;
   logic [3:0]    lad_out;
   logic          lad_oe;
   logic [AW-1:0] mem_addr;
   logic          mem_req;
   logic [7:0]    mem_rdata;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;
   logic [1:0] reqd;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpc_rd_target #(.ADDR_W(AW), .MEM_LAT(BLAT)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_n   (frame_n),
      .lad_in    (lad_in),
      .lad_out   (lad_out),
      .lad_oe    (lad_oe),
      .mem_addr  (mem_addr),
      .mem_req   (mem_req),
      .mem_rdata (mem_rdata)
   );

   function automatic logic [7:0] mem_fn(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
   endfunction

   // memory model: correct byte only in the clock BLAT after the request
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) reqd <= '0;
      else        reqd <= {reqd[0], mem_req};
   end
   assign mem_rdata = reqd[BLAT-1] ? mem_fn(mem_addr) : ~mem_fn(mem_addr);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic quiet(input string req);
      chk(!lad_oe && !mem_req, req, {lad_oe, mem_req}, 0);
   endtask

   // frame high, arbitrary nibbles, target must stay silent
   task automatic idle_stream(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         quiet("R2 idle");
         frame_n = 1'b1;
         lad_in  = 4'(i);
      end
   endtask

   // n clocks with frame low: earlier nibbles pre, last one last
   task automatic send_start(input int n, input logic [3:0] pre, input logic [3:0] last);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frame_n = 1'b0;
         lad_in  = (i == n - 1) ? last : pre;
      end
   endtask

   // clocks 2..17 of a read; abort_clk>0 drives a new start in that clock
   task automatic do_read(input logic [3:0] ctype, input logic [AW-1:0] addr,
                          input bit ok, input int abort_clk);
      logic [7:0] b;
      b = mem_fn(addr);
      for (int c = 2; c <= 17; c++) begin
         @(negedge clk);
         if (!ok) quiet("R10/R4 rejected cycle");
         else begin
            case (c)
               11: begin
                  chk(mem_req && !lad_oe, "R5/R6 turnaround-0 request", {lad_oe, mem_req}, 1);
                  chk(mem_addr == addr, "R5 address order", mem_addr, addr);
               end
               12: chk(lad_oe && lad_out == 4'hF && !mem_req, "R6 turnaround-1 drive", {lad_oe, lad_out}, 5'h1F);
               13: chk(lad_oe && lad_out == 4'h0, "R7 sync", {lad_oe, lad_out}, 5'h10);
               14: chk(lad_oe && lad_out == b[3:0], "R8 low nibble", {lad_oe, lad_out}, {1'b1, b[3:0]});
               15: chk(lad_oe && lad_out == b[7:4], "R8 high nibble", {lad_oe, lad_out}, {1'b1, b[7:4]});
               16: chk(lad_oe && lad_out == 4'hF, "R9 closing drive", {lad_oe, lad_out}, 5'h1F);
               17: chk(!lad_oe, "R9 release", lad_oe, 0);
               default: quiet("R4 decode phase");
            endcase
         end
         if (abort_clk != 0 && c == abort_clk) begin
            frame_n = 1'b0;
            lad_in  = 4'h0;
            return;
         end
         frame_n = 1'b1;
         if (c == 2)       lad_in = ctype;
         else if (c <= 10) lad_in = addr[AW-1-4*(c-3) -: 4];
         else              lad_in = 4'hF;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      quiet("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      quiet("R1 after reset");

      // R2 idle with every nibble value
      idle_stream(32);

      // R4 / R10 sweep of all cycle types
      for (int ct = 0; ct < 16; ct++) begin
         logic [3:0] t;
         t = 4'(ct);
         send_start(1, 4'h0, 4'h0);
         do_read(t, 32'hA5C3_0F96 + AW'(ct), t[3:1] == 3'b010, 0);
         idle_stream(2);
      end

      // R5 / R8 address patterns, including back-to-back reads (R9)
      send_start(1, 4'h0, 4'h0); do_read(4'h4, 32'h0000_0000, 1'b1, 0);
      send_start(1, 4'h0, 4'h0); do_read(4'h5, 32'hFFFF_FFFF, 1'b1, 0);
      send_start(1, 4'h0, 4'h0); do_read(4'h4, 32'h1234_5678, 1'b1, 0);
      send_start(1, 4'h0, 4'h0); do_read(4'h4, 32'h8765_4321, 1'b1, 0);
      for (int k = 0; k < AW; k++) begin
         send_start(1, 4'h0, 4'h0);
         do_read(4'h4, AW'(1) << k, 1'b1, 0);
      end

      // R3 long start runs: last nibble decides
      send_start(4, 4'h7, 4'h0); do_read(4'h4, 32'hDEAD_BEEF, 1'b1, 0);
      send_start(4, 4'h0, 4'h3); do_read(4'h4, 32'hDEAD_BEEF, 1'b0, 0);
      idle_stream(3);

      // R10 invalid type then valid start recovers
      send_start(1, 4'h0, 4'h0); do_read(4'h6, 32'h0BAD_0BAD, 1'b0, 0);
      send_start(1, 4'h0, 4'h0); do_read(4'h4, 32'h0600_D00D, 1'b1, 0);

      // R11 abort during sync, restart in the same clock
      send_start(1, 4'h0, 4'h0);
      do_read(4'h4, 32'h1111_2222, 1'b1, 13);
      do_read(4'h4, 32'h3333_4444, 1'b1, 0);
      idle_stream(4);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule